// File: doc/BRIEF.md
# Dual-Lane ADC Word Serializer

This block takes one 16-bit conversion result per pixel and sends it on two output lanes over eight transfer slots, two bits per slot. Lane 1 carries the odd-index bits and lane 0 the even-index bits, most-significant pair first. A result is offered on `word_in` with a one-cycle `load` strobe. It waits in a one-word holding register until a word boundary, and then moves into the shifter.

The block runs on a fast system clock. Two per-cycle enables report the output clock's edges: `rise_en` for rising edges and `fall_en` for falling edges. In single-edge mode (`mode_dbl` = 0), a slot advances only on `rise_en`. In double-edge mode (`mode_dbl` = 1), a slot advances on either enable, so the slot rate is twice the edge rate. With the output clock at 8x the pixel rate in single-edge mode and 4x in double-edge mode, eight slots fill one pixel period. `word_start` is high for the whole of each word's first slot.

The controller has two states. In `ST_IDLE` the lanes are driven low. In `ST_SEND` a word is being shifted out. The transitions are:
- `T_START` (`ST_IDLE` to `ST_SEND`): a step occurs with a word held.
- `T_NEXT` (`ST_SEND` to `ST_SEND`): a step occurs before the last slot.
- `T_CHAIN` (`ST_SEND` to `ST_SEND`, new word): a step occurs on the last slot with a word held.
- `T_DRAIN` (`ST_SEND` to `ST_IDLE`): a step occurs on the last slot with nothing held.

Top module: `dual_lane_serializer`

## Requirements
- R1: While `rst_n` is low, `lane_out` is 0 and `word_start` is 0, and the block leaves reset in `ST_IDLE` with no word held.
- R2: A word is sent as 8 slots of 2 bits. In the first slot, `lane_out[1]` equals bit 15 and `lane_out[0]` equals bit 14.
- R3: In slot k (k = 0..7), `lane_out[1]` equals bit 15-2k and `lane_out[0]` equals bit 14-2k. Lane 1 therefore carries the odd bits in descending order and lane 0 the even bits in descending order.
- R4: With `mode_dbl` = 0, a slot step occurs only in a cycle with `rise_en` = 1. A `fall_en` pulse on its own leaves `lane_out` and `word_start` unchanged.
- R5: With `mode_dbl` = 1, a slot step occurs in every cycle where `rise_en` or `fall_en` is 1.
- R6: `lane_out` changes only in the cycle after a slot step. Between steps it holds its value.
- R7: A `load` that arrives while a word is being sent is held. The word in progress finishes all 8 slots unchanged.
- R8: When a word is held at the step that ends slot 7, that same step starts the held word in slot 0, with no idle slot in between.
- R9: A later `load` before the held word has started replaces the held word. Only the newest word is sent.
- R10: `word_start` is 1 during slot 0 of every word and 0 otherwise.
- R11: When the step that ends slot 7 finds no word held, the block returns to `ST_IDLE` and drives `lane_out` = 0 and `word_start` = 0.
- R12: A `load` in idle is taken at the first step in a later cycle. A step in the same cycle as the strobe does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dbl | input | 1 | 0: single-edge slot rate; 1: double-edge slot rate |
| rise_en | input | 1 | One-cycle enable marking an output-clock rising edge |
| fall_en | input | 1 | One-cycle enable marking an output-clock falling edge |
| load | input | 1 | Strobe that captures `word_in` into the holding register |
| word_in | input | 16 | Parallel conversion result |
| lane_out | output | 2 | Data lanes; bit 1 is the odd-bit lane, bit 0 the even-bit lane |
| word_start | output | 1 | High during the first slot of each word |

## Verification
The bench goes after the word boundary. It issues strobes in the middle of a word, on the last slot, and in the same cycle as a step. A design that took a strobe at once would corrupt the word being sent. A design that waited one slot extra would leave a gap between chained words.

Two strobes close together check that the newest word wins; keeping the older one would send stale data. In single-edge mode the bench sends lone falling-edge enables, which a design that ignored the mode would treat as steps, sending slots at double rate. The bit order is checked with asymmetric patterns, so a lane swap or an odd/even mix-up shows up as a lane mismatch.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } dls_state_e;

endpackage

// File: rtl/dls_step_gen.sv
module dls_step_gen (
    input  logic mode_dbl,
    input  logic rise_en,
    input  logic fall_en,
    output logic step
);

    // One slot per rising edge, or one per edge of either kind.
    always_comb begin
        if (mode_dbl)
            step = rise_en | fall_en;
        else
            step = rise_en;
    end

endmodule

// File: rtl/dls_hold.sv
module dls_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    input  logic              take,
    output logic              pend_valid,
    output logic [WORD_W-1:0] pend_word
);

    // A fresh strobe wins over a take in the same cycle: the newer word stays held.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_word  <= '0;
        end else if (load) begin
            pend_valid <= 1'b1;
            pend_word  <= din;
        end else if (take) begin
            pend_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dls_shift.sv
module dls_shift #(
    parameter int WORD_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic [LANES-1:0]  chunk_out
);

    logic [WORD_W-1:0] shreg_q;

    // On load, the top group goes straight to the lanes, so the remainder is stored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg_q <= '0;
        else if (load)
            shreg_q <= din << LANES;
        else if (shift)
            shreg_q <= shreg_q << LANES;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane_tap
        assign chunk_out[l] = shreg_q[WORD_W-LANES+l];
    end

endmodule

// File: rtl/dual_lane_serializer.sv
module dual_lane_serializer #(
    parameter int WORD_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dbl,
    input  logic              rise_en,
    input  logic              fall_en,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    output logic [LANES-1:0]  lane_out,
    output logic              word_start
);

    import dls_pkg::*;

    localparam int SLOTS = WORD_W / LANES;
    localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

    dls_state_e       state_q, state_d;
    logic [CNT_W-1:0] slot_q;
    logic             step;
    logic             pend_valid;
    logic [WORD_W-1:0] pend_word;
    logic [LANES-1:0] chunk_next;
    logic [LANES-1:0] lane_q;
    logic             start_q;
    logic             at_boundary;
    logic             take;
    logic             advance;

    dls_step_gen u_step (
        .mode_dbl (mode_dbl),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .step     (step)
    );

    dls_hold #(.WORD_W(WORD_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .din        (word_in),
        .take       (take),
        .pend_valid (pend_valid),
        .pend_word  (pend_word)
    );

    dls_shift #(.WORD_W(WORD_W), .LANES(LANES)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .shift     (advance),
        .din       (pend_word),
        .chunk_out (chunk_next)
    );

    assign at_boundary = (state_q == ST_IDLE) || (slot_q == LAST_SLOT);
    assign take        = step && at_boundary && pend_valid;
    assign advance     = step && (state_q == ST_SEND) && (slot_q != LAST_SLOT);

    // Next-state decode (T_START, T_NEXT, T_CHAIN, T_DRAIN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take)
                    state_d = ST_SEND;                   // T_START
            end
            ST_SEND: begin
                if (step && slot_q == LAST_SLOT)
                    state_d = take ? ST_SEND : ST_IDLE;  // T_CHAIN / T_DRAIN
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and slot counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take)
                slot_q <= '0;
            else if (advance)
                slot_q <= slot_q + 1'b1;                 // T_NEXT
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q  <= '0;
            start_q <= 1'b0;
        end else if (step) begin
            if (take) begin
                lane_q  <= pend_word[WORD_W-1 -: LANES];
                start_q <= 1'b1;
            end else if (advance) begin
                lane_q  <= chunk_next;
                start_q <= 1'b0;
            end else begin
                lane_q  <= '0;
                start_q <= 1'b0;
            end
        end
    end

    assign lane_out   = lane_q;
    assign word_start = start_q;

endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
    parameter int WORD_W = 16,
    parameter int LANES  = 2,
    parameter int CNT_W  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mode_dbl,
    input logic                  rise_en,
    input logic                  fall_en,
    input logic [LANES-1:0]      lane_out,
    input logic                  word_start,
    input dls_pkg::dls_state_e   state_q,
    input logic [CNT_W-1:0]      slot_q,
    input logic                  pend_valid
);

    import dls_pkg::*;

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORD_W / LANES - 1);

    logic step_p;
    logic edge_p;
    assign step_p = rise_en | (mode_dbl & fall_en);
    assign edge_p = (state_q == ST_IDLE) || (slot_q == LAST_SLOT);

    always @(posedge clk) begin
        if (!rst_n)
            assert_reset_quiet_R1: assert (lane_out == '0 && !word_start);
    end

    assert_single_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dbl && !rise_en && fall_en) |=> ($stable(lane_out) && $stable(word_start)));

    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_p |=> $stable(lane_out));

    assert_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !(step_p && edge_p)) |=> pend_valid);

    assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_p && state_q == ST_SEND && slot_q == LAST_SLOT && pend_valid)
        |=> (word_start && state_q == ST_SEND && slot_q == '0));

    assert_start_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && !step_p) |=> word_start);

    assert_start_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && step_p) |=> !word_start);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (lane_out == '0 && !word_start));

    assert_idle_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !pend_valid) |=> !word_start);

endmodule

bind dual_lane_serializer dls_checker #(
    .WORD_W (WORD_W),
    .LANES  (LANES),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_dbl   (mode_dbl),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .lane_out   (lane_out),
    .word_start (word_start),
    .state_q    (state_q),
    .slot_q     (slot_q),
    .pend_valid (pend_valid)
);

// File: tb/sim_dual_lane_serializer.sv
module sim_dual_lane_serializer;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        mode_dbl = 1'b0;
    logic        rise_en = 1'b0;
    logic        fall_en = 1'b0;
    logic        load = 1'b0;
    logic [15:0] word_in = '0;
    logic [1:0]  lane_out;
    logic        word_start;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    dual_lane_serializer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_dbl   (mode_dbl),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .load       (load),
        .word_in    (word_in),
        .lane_out   (lane_out),
        .word_start (word_start)
    );

    // Reference model: slot index -1 means idle.
    bit          m_pv;
    logic [15:0] m_pw;
    logic [15:0] m_cur;
    int          m_slot = -1;
    bit          m_step;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pv   = 1'b0;
            m_slot = -1;
        end else begin
            m_step = rise_en || (mode_dbl && fall_en);
            if (m_step) begin
                if (m_slot == -1 || m_slot == 7) begin
                    if (m_pv) begin
                        m_cur  = m_pw;
                        m_slot = 0;
                        m_pv   = 1'b0;
                    end else begin
                        m_slot = -1;
                    end
                end else begin
                    m_slot++;
                end
            end
            if (load) begin
                m_pv = 1'b1;
                m_pw = word_in;
            end
        end
    end

    function automatic int exp_lanes();
        if (m_slot < 0) return 0;
        return {m_cur[15-2*m_slot], m_cur[14-2*m_slot]};
    endfunction

    task automatic check(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "lanes", int'(lane_out), exp_lanes());
            check("R10", "word_start", int'(word_start), (m_slot == 0) ? 1 : 0);
        end
    end

    task automatic drv(bit r, bit f, bit l, logic [15:0] w);
        @(negedge clk);
        rise_en = r;
        fall_en = f;
        load    = l;
        word_in = w;
    endtask

    task automatic idle();
        drv(1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [1:0] held;
        int lfsr;
        repeat (3) @(negedge clk);
        check("R1", "reset lanes", int'(lane_out), 0);
        check("R1", "reset start", int'(word_start), 0);
        rst_n = 1'b1;

        // R12: a strobe and a step in the same cycle; the word must wait.
        cur_req = "R12";
        drv(1'b1, 1'b0, 1'b1, 16'hA5C3);
        idle();
        check("R12", "no start on same-cycle step", int'(word_start), 0);
        drv(1'b1, 1'b0, 1'b0, 16'h0);
        idle();
        check("R2", "first slot D15/D14", int'(lane_out), 2);
        check("R10", "first slot marker", int'(word_start), 1);

        // R4: single-edge mode; lone falling-edge enables are ignored.
        cur_req = "R4";
        held = lane_out;
        drv(1'b0, 1'b1, 1'b0, 16'h0);
        idle();
        check("R4", "fall ignored in single mode", int'(lane_out), int'(held));
        for (int i = 0; i < 64; i++) begin
            drv(i % 4 == 0, i % 4 == 2, i == 9, 16'h3E71);
        end
        repeat (4) idle();

        // R3: bit order with steps on every cycle.
        cur_req = "R3";
        drv(1'b0, 1'b0, 1'b1, 16'h6C39);
        for (int i = 0; i < 10; i++) drv(1'b1, 1'b0, 1'b0, 16'h0);
        idle();

        // R5 and R7: double-edge mode with strobes mid-word.
        cur_req = "R5";
        mode_dbl = 1'b1;
        for (int i = 0; i < 60; i++) begin
            drv(i % 3 == 0, i % 3 == 1, i == 4 || i == 31, 16'hF00D ^ 16'(i * 16'h0111));
        end
        cur_req = "R7";
        drv(1'b0, 1'b0, 1'b1, 16'h8001);
        drv(1'b1, 1'b0, 1'b0, 16'h0);
        for (int i = 0; i < 3; i++) drv(1'b0, 1'b1, 1'b0, 16'h0);
        drv(1'b0, 1'b0, 1'b1, 16'h7FFE);
        for (int i = 0; i < 24; i++) drv(i % 2 == 0, i % 2 == 1, 1'b0, 16'h0);

        // R8: back-to-back words, strobe placed on the last slot.
        cur_req = "R8";
        for (int i = 0; i < 48; i++) begin
            drv(1'b1, 1'b0, i % 8 == 6, 16'h1234 + 16'(i));
        end

        // R9: two strobes before the held word starts; newest wins.
        cur_req = "R9";
        drv(1'b0, 1'b0, 1'b1, 16'hDEAD);
        drv(1'b0, 1'b0, 1'b1, 16'hBEEF);
        for (int i = 0; i < 20; i++) drv(1'b0, 1'b1, 1'b0, 16'h0);

        // R11: drain to idle.
        cur_req = "R11";
        for (int i = 0; i < 12; i++) drv(1'b1, 1'b0, 1'b0, 16'h0);
        idle();
        check("R11", "idle lanes", int'(lane_out), 0);

        // R6: sparse pseudo-random steps in both modes.
        cur_req = "R6";
        lfsr = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            mode_dbl = lfsr[9];
            drv(lfsr[0] & lfsr[3], lfsr[1] & lfsr[4], lfsr[2] & lfsr[5] & lfsr[6],
                16'(lfsr * 7));
        end
        repeat (4) idle();

        done = 1'b1;
        finish_run();
    end

endmodule